// File: doc/BRIEF.md
# Slot-Timed CSMA/CA Backoff and Acknowledgement Controller

This block is the transmit-side medium access controller of a slotted radio link. It acts only in clock cycles where `slot_tick_i` is high. When a frame is waiting it looks at the channel-busy flag. If the channel is idle it starts a transmission at once. If the channel is busy it draws a random backoff and counts it down, one step per idle slot. The count holds its value while the channel stays busy and resumes from that value afterwards. When the count is used up the block asks the transmitter to start.

After the transmitter reports completion, the block waits a programmable number of slots for an acknowledgement. A missing acknowledgement counts as a failure. On a failure the contention window grows and the frame goes back to backoff. The frame is abandoned after its eighth consecutive failure. A success resets the window. If another frame is already waiting, it goes straight into a fresh backoff.

Random values come from a 16-bit LFSR. The LFSR steps only when a backoff is drawn, so the sequence of draws is fully predictable from reset.

Top module: `csma_tx_ctrl`

## Requirements
- R1: After reset, `state_o` reads 0 (idle), `tx_start_o`, `success_o` and `drop_o` are low, the contention window is 15, and the LFSR holds 16'hACE1.
- R2: The `state_o` encoding is: idle 0, sense 1, backoff 2, transmit 3, wait-ack 4, end-of-transmission 5. In idle, a slot tick with `frame_pend_i` high moves the block to sense. In sense, a tick with the channel idle moves it to transmit. In sense, a tick with the channel busy moves it to backoff with a new draw.
- R3: The contention window starts at 15. After each failed attempt it becomes 2*cw+1, with a ceiling of 1023. It returns to 15 after a success or a drop.
- R4: In backoff, a tick with `chan_busy_i` high leaves the count unchanged. An idle tick with a nonzero count decrements it. An idle tick with a zero count moves the block to transmit. A draw of v therefore lasts exactly v+1 idle ticks, plus any busy ticks.
- R5: `tx_start_o` is high for exactly one clock cycle: the cycle after the tick that enters transmit. The block stays in transmit until a tick with `tx_done_i` high, which moves it to wait-ack.
- R6: In wait-ack with timeout T = `ack_timeout_i`, a tick with `ack_rx_i` high, among the first T+1 ticks, moves the block to end-of-transmission. `success_o` is then high for one cycle. If the T+1st tick passes without an acknowledgement, the attempt has failed.
- R7: A draw equals the low 10 LFSR bits ANDed with the window in force. For a failure this is the grown window. The LFSR is a right-shifting Fibonacci register with feedback s[0]^s[2]^s[3]^s[5] entering bit 15, and it steps once per draw, after the value is taken.
- R8: In end-of-transmission, a tick with `frame_pend_i` high starts a new draw from the minimum window and moves the block to backoff. A tick without a pending frame returns the block to idle.
- R9: Failures one to seven of a frame send it back to backoff. The eighth failure returns the block to idle with `drop_o` high for one cycle.
- R10: In cycles where `slot_tick_i` is low, all other inputs are ignored and the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_tick_i | input | 1 | One-cycle strobe marking a slot boundary |
| frame_pend_i | input | 1 | A frame is waiting to be sent |
| chan_busy_i | input | 1 | Energy detected on the channel in this slot |
| tx_done_i | input | 1 | Transmitter finished sending the frame |
| ack_rx_i | input | 1 | Acknowledgement received in this slot |
| ack_timeout_i | input | TO_W | Acknowledgement wait, T+1 slots |
| tx_start_o | output | 1 | Pulse: begin transmission |
| state_o | output | 3 | Current controller state |
| success_o | output | 1 | Pulse: frame acknowledged |
| drop_o | output | 1 | Pulse: frame abandoned after retry limit |

## Verification
The hardest case to reach is the drop path. A single frame must fail eight times in a row, and its window must climb to the 1023 ceiling while the backoffs are counted down with busy slots mixed in. The bench reaches it with a long phase in which acknowledgements are never returned. During that phase the busy flag and the transmitter-done flag keep varying. A slot-by-slot reference model and a measured idle-slot count per backoff confirm each draw and each window step. Between ticks, the bench drives every input active to show that nothing moves off a tick.

// File: rtl/csma_pkg.sv
package csma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SENSE    = 3'd1,
    ST_BACKOFF  = 3'd2,
    ST_TX       = 3'd3,
    ST_WAIT_ACK = 3'd4,
    ST_EOT      = 3'd5
  } state_e;
endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   SEED = 16'hACE1,
  parameter logic [W-1:0]   TAPS = 16'h002D
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic         fb;

  assign fb  = ^(q_q & TAPS);
  assign q_o = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= SEED;
    else if (step_i) q_q <= {fb, q_q[W-1:1]};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_q != '0); // R7
endmodule

// File: rtl/csma_cw.sv
module csma_cw #(
  parameter int MIN_LOG = 4,
  parameter int MAX_LOG = 10,
  localparam int CW_W   = MAX_LOG
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            grow_i,
  input  logic            clr_i,
  output logic [CW_W-1:0] cw_o,
  output logic [CW_W-1:0] cw_grown_o
);
  localparam logic [CW_W-1:0] CW_MIN = {{(CW_W-MIN_LOG){1'b0}}, {MIN_LOG{1'b1}}};
  localparam logic [CW_W-1:0] CW_MAX = '1;

  logic [CW_W-1:0] cw_q;

  assign cw_grown_o = (cw_q == CW_MAX) ? cw_q : {cw_q[CW_W-2:0], 1'b1};
  assign cw_o       = cw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cw_q <= CW_MIN;
    else if (clr_i)  cw_q <= CW_MIN;
    else if (grow_i) cw_q <= cw_grown_o;
  end

  AST_CW_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw_q >= CW_MIN) && ((cw_q & (cw_q + 1'b1)) == '0)); // R3
endmodule

// File: rtl/csma_down_cnt.sv
module csma_down_cnt #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> (cnt_q != '0)); // R4
endmodule

// File: rtl/csma_tx_ctrl.sv
module csma_tx_ctrl
  import csma_pkg::*;
#(
  parameter int          CW_MIN_LOG = 4,
  parameter int          CW_MAX_LOG = 10,
  parameter int          TO_W       = 8,
  parameter int          MAX_RETRY  = 7,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            slot_tick_i,
  input  logic            frame_pend_i,
  input  logic            chan_busy_i,
  input  logic            tx_done_i,
  input  logic            ack_rx_i,
  input  logic [TO_W-1:0] ack_timeout_i,
  output logic            tx_start_o,
  output logic [2:0]      state_o,
  output logic            success_o,
  output logic            drop_o
);
  localparam int CW_W  = CW_MAX_LOG;
  localparam int CNT_W = (CW_W > TO_W) ? CW_W : TO_W;
  localparam int RTY_W = $clog2(MAX_RETRY + 1);
  localparam logic [RTY_W-1:0] RTY_LAST = RTY_W'(MAX_RETRY);

  state_e state_q, state_d;
  logic [RTY_W-1:0] fail_q, fail_d;
  logic tx_q, tx_d, succ_q, succ_d, drop_q, drop_d;

  logic [15:0]      lfsr_q;
  logic [CW_W-1:0]  cw, cw_grown;
  logic [CNT_W-1:0] cnt, cnt_val;
  logic cnt_zero, cnt_load, cnt_dec;
  logic draw, use_grown, cw_grow, cw_clr;

  csma_lfsr #(.W(16), .SEED(LFSR_SEED)) i_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (draw),
    .q_o    (lfsr_q)
  );

  csma_cw #(.MIN_LOG(CW_MIN_LOG), .MAX_LOG(CW_MAX_LOG)) i_cw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grow_i     (cw_grow),
    .clr_i      (cw_clr),
    .cw_o       (cw),
    .cw_grown_o (cw_grown)
  );

  // one counter serves backoff and ack timeout; the states never overlap
  csma_down_cnt #(.W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .dec_i      (cnt_dec),
    .cnt_o      (cnt),
    .zero_o     (cnt_zero)
  );

  always_comb begin
    state_d   = state_q;
    fail_d    = fail_q;
    tx_d      = 1'b0;
    succ_d    = 1'b0;
    drop_d    = 1'b0;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    cnt_dec   = 1'b0;
    draw      = 1'b0;
    use_grown = 1'b0;
    cw_grow   = 1'b0;
    cw_clr    = 1'b0;
    if (slot_tick_i) begin
      unique case (state_q)
        ST_IDLE: if (frame_pend_i) begin
          state_d = ST_SENSE;
          fail_d  = '0;
        end
        ST_SENSE: begin
          if (!chan_busy_i) begin
            state_d = ST_TX;
            tx_d    = 1'b1;
          end else begin
            state_d = ST_BACKOFF;
            draw    = 1'b1;
          end
        end
        ST_BACKOFF: if (!chan_busy_i) begin
          if (cnt_zero) begin
            state_d = ST_TX;
            tx_d    = 1'b1;
          end else begin
            cnt_dec = 1'b1;
          end
        end
        ST_TX: if (tx_done_i) begin
          state_d  = ST_WAIT_ACK;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(ack_timeout_i);
        end
        ST_WAIT_ACK: begin
          if (ack_rx_i) begin
            state_d = ST_EOT;
            succ_d  = 1'b1;
            cw_clr  = 1'b1;
          end else if (cnt_zero) begin
            if (fail_q == RTY_LAST) begin
              state_d = ST_IDLE;
              drop_d  = 1'b1;
              cw_clr  = 1'b1;
              fail_d  = '0;
            end else begin
              state_d   = ST_BACKOFF;
              fail_d    = fail_q + 1'b1;
              cw_grow   = 1'b1;
              use_grown = 1'b1;
              draw      = 1'b1;
            end
          end else begin
            cnt_dec = 1'b1;
          end
        end
        ST_EOT: begin
          if (frame_pend_i) begin
            state_d = ST_BACKOFF;
            fail_d  = '0;
            draw    = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
    if (draw) begin
      cnt_load = 1'b1;
      cnt_val  = CNT_W'(lfsr_q[CW_W-1:0] & (use_grown ? cw_grown : cw));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fail_q  <= '0;
      tx_q    <= 1'b0;
      succ_q  <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fail_q  <= fail_d;
      tx_q    <= tx_d;
      succ_q  <= succ_d;
      drop_q  <= drop_d;
    end
  end

  assign state_o    = state_q;
  assign tx_start_o = tx_q;
  assign success_o  = succ_q;
  assign drop_o     = drop_q;

  AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_tick_i |=> $stable(state_q)); // R10
  AST_TX_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> (state_q == ST_TX && $past(state_q) != ST_TX)); // R5
  AST_BO_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_tick_i && chan_busy_i && state_q == ST_BACKOFF) |=> (state_q == ST_BACKOFF && $stable(cnt))); // R4
  AST_SUCCESS_EOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    success_o |-> state_q == ST_EOT); // R6
  AST_DROP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> state_q == ST_IDLE); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({tx_start_o, success_o, drop_o}) <= 1); // R8
  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd5); // R2
endmodule

// File: tb/test_csma_tx_ctrl.sv
`timescale 1ns/1ps
module test_csma_tx_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, pend = 1'b0, busy = 1'b0, done = 1'b0, ack = 1'b0;
  logic [7:0] tmo = 8'd0;
  logic tx_start, success, drop;
  logic [2:0] state;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  csma_tx_ctrl i_csma_tx_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .slot_tick_i(tick), .frame_pend_i(pend),
    .chan_busy_i(busy), .tx_done_i(done), .ack_rx_i(ack), .ack_timeout_i(tmo),
    .tx_start_o(tx_start), .state_o(state), .success_o(success), .drop_o(drop)
  );

  // reference model
  int m_state = 0, m_cnt = 0, m_cw = 15, m_fail = 0;
  logic [15:0] m_lfsr = 16'hACE1;
  int last_draw = 0, dut_idle = 0;
  int n_drop = 0, n_succ = 0, max_cw = 15;
  int unsigned seed = 32'h1234_5678;

  function automatic int draw_val(int cwv);
    int v;
    v = int'(m_lfsr[9:0]) & cwv;
    m_lfsr = {m_lfsr[0] ^ m_lfsr[2] ^ m_lfsr[3] ^ m_lfsr[5], m_lfsr[15:1]};
    return v;
  endfunction

  function automatic int rnd(int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % m);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic slot(input logic p, input logic b, input logic d, input logic a, input int t);
    int e_tx, e_s, e_d, prev_dut;
    string tag;
    e_tx = 0; e_s = 0; e_d = 0;
    @(negedge clk);
    pend = p; busy = b; done = d; ack = a; tmo = 8'(t); tick = 1'b1;
    prev_dut = int'(state);
    case (m_state)
      0: begin tag = "R2"; if (p) begin m_state = 1; m_fail = 0; end end
      1: begin tag = "R2";
        if (!b) begin m_state = 3; e_tx = 1; end
        else begin m_state = 2; m_cnt = draw_val(m_cw); last_draw = m_cnt; end
      end
      2: begin tag = "R4";
        if (!b) begin
          if (m_cnt == 0) begin m_state = 3; e_tx = 1; end
          else m_cnt--;
        end
      end
      3: begin tag = "R5"; if (d) begin m_state = 4; m_cnt = t; end end
      4: begin tag = "R6";
        if (a) begin m_state = 5; e_s = 1; m_cw = 15; end
        else if (m_cnt == 0) begin
          tag = "R9";
          if (m_fail == 7) begin m_state = 0; e_d = 1; m_cw = 15; m_fail = 0; end
          else begin
            m_fail++;
            m_cw = (m_cw == 1023) ? 1023 : 2 * m_cw + 1;
            if (m_cw > max_cw) max_cw = m_cw;
            m_state = 2; m_cnt = draw_val(m_cw); last_draw = m_cnt;
          end
        end else m_cnt--;
      end
      default: begin tag = "R8";
        if (p) begin m_state = 2; m_fail = 0; m_cnt = draw_val(m_cw); last_draw = m_cnt; end
        else m_state = 0;
      end
    endcase
    @(negedge clk);
    check(tag, int'(state), m_state);
    check("R5 tx_start", int'(tx_start), e_tx);
    check("R6 success", int'(success), e_s);
    check("R9 drop", int'(drop), e_d);
    if (e_s == 1) n_succ++;
    if (e_d == 1) n_drop++;
    // measured idle-slot length of each backoff
    if (prev_dut == 2) begin
      if (!b) dut_idle++;
      if (int'(state) != 2) begin
        check("R3 R7 backoff idle slots", dut_idle, last_draw + 1);
        dut_idle = 0;
      end
    end else dut_idle = 0;
    // between ticks every input active: nothing may move (R10)
    tick = 1'b0; pend = 1'b1; busy = ~b; done = 1'b1; ack = 1'b1;
    repeat (3) @(negedge clk);
    if (int'(state) != m_state || tx_start || success || drop) begin
      n_vec++; n_bad++;
      $display("FAIL R10 state=%0d expected=%0d pulses=%0d%0d%0d expected 000",
               state, m_state, tx_start, success, drop);
    end else n_vec++;
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 state", int'(state), 0);
    check("R1 pulses", int'({tx_start, success, drop}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 state after release", int'(state), 0);
    for (int s = 0; s < 14000; s++) begin
      logic p, b, d, a;
      int t;
      t = (s / 500) % 4;
      p = (rnd(4) != 0);
      d = (rnd(2) == 0);
      if (s >= 2000 && s < 9000) begin
        a = 1'b0; b = (rnd(8) == 0);          // ack-starved phase: reach drop
      end else if (s >= 9000 && s < 9300) begin
        a = (rnd(2) == 0); b = (rnd(4) != 0); // long busy stretches
      end else begin
        a = (rnd(3) == 0); b = (rnd(3) == 0);
      end
      slot(p, b, d, a, t);
    end
    check("R9 drop reached", int'(n_drop > 0), 1);
    check("R3 window ceiling reached", max_cw, 1023);
    check("R6 successes seen", int'(n_succ > 0), 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule